// File: doc/BRIEF.md
# Stateful Packet ALU

This block is the stateful update unit of one packet-processing pipeline stage. It holds one state word, or a pair of state words, and for every packet that arrives it reads the state and evaluates a configured predicate. It then writes back an updated value and hands a result word back to the packet. The whole read-modify-write completes inside a single clock cycle, so every packet sees the value written by the packet just before it, even with no gap between them.

The update rule comes from configuration ports that a compiler or control plane holds static while traffic flows. The rules form a ladder of growing expressiveness:

- a plain load;
- an accumulate;
- a guarded accumulate;
- a two-way choice between two add arms;
- the same choice with subtraction;
- a four-way nested choice;
- a paired update of two state words.

All four arithmetic arms are computed in parallel, and multiplexers pick the result. A wrap-around sampling counter maps onto the two-way mode. It uses an equality predicate against constant 9: one arm resets the count to zero and the other adds one.

Top module: `stateful_alu`

## Requirements

**Outputs and predicates**

- R1: After a synchronous active-low reset, both state words are zero, and out_valid, out_val, out_pair and out_flag are zero.
- R9: Predicate P compares lhs with rhs, unsigned, using cfg_p_op:
  - 0 means greater-than, 1 means less-than, 2 means equal, 3 means always true.
  - lhs is in_a when cfg_p_lhs=1, otherwise state0.
  - rhs is cfg_k0 when cfg_p_rhs=1, otherwise in_b.
  - Predicate Q compares in_a with in_b under cfg_q_op, using the same codes.
  - out_flag reports P for every accepted packet.
- R11: A packet accepted at clock edge N produces out_valid high after edge N and low otherwise.
  - out_val carries the new state0 when cfg_export_new=1 and the old state0 when cfg_export_new=0.
  - out_pair does the same for state1.
  - The data outputs hold their values while out_valid is low.

**Arms and modes**

Arm k of cfg_arms sits at bits 4k+3:4k. Each arm's fields are:

- bit 0 picks the base: 1 for the state word, 0 for zero.
- bits 2:1 pick the operand: 0 for in_a, 1 for in_b, 2 for cfg_k1, 3 for zero.
- bit 3 requests base minus operand instead of base plus operand.

The arms combine with the mode as follows:

- R2: Mode 0 (load) writes state0 with the operand of arm 0. The base and subtract bits are ignored.
- R3: Mode 1 (accumulate) writes state0 with the base of arm 0 plus its operand, modulo 2^W. The subtract bit is ignored.
- R4: Mode 2 (guarded) writes arm 0's sum when P holds and leaves state0 unchanged when it does not.
- R5: Mode 3 (two-way) writes arm 0's sum when P holds and arm 1's sum otherwise. The subtract bits are ignored.
- R6: Mode 4 (two-way with subtract) behaves as mode 3 but honours the subtract bits.
- R7: Mode 5 (nested) writes one arm into state0, with subtract bits honoured:
  - arm 0 when P and Q hold;
  - arm 1 when P holds and Q does not;
  - arm 2 when Q holds and P does not;
  - arm 3 when neither holds.
- R8: Mode 6 (pair) updates both words in one operation, with subtract bits honoured.
  - When P holds, state0 takes arm 0 and state1 takes arm 1.
  - Otherwise state0 takes arm 2 and state1 takes arm 3.
  - Arms 1 and 3 use state1 as their base.
  - In every other mode state1 is unchanged.

**Timing and idle behaviour**

- R10: Back-to-back packets each observe the state written by the packet one cycle earlier, with no stall.
- R12: A cycle with in_valid low changes no state. Mode 7 (hold) leaves both state words unchanged.
- R13: A sampling counter can be configured in mode 3:
  - The predicate is state0 equal to cfg_k0=9.
  - Arm 0 is zero plus zero.
  - Arm 1 is state plus cfg_k1=1.
  - Under this setting, every tenth packet sees out_flag=1 with the count returning to 0, and the other packets see out_flag=0.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 3 | Update mode, 0 to 7 |
| cfg_p_op | input | 2 | Comparison code for predicate P |
| cfg_p_lhs | input | 1 | P left side: 1 in_a, 0 state0 |
| cfg_p_rhs | input | 1 | P right side: 1 cfg_k0, 0 in_b |
| cfg_q_op | input | 2 | Comparison code for predicate Q (in_a vs in_b) |
| cfg_k0 | input | W | Predicate constant |
| cfg_k1 | input | W | Operand constant |
| cfg_arms | input | 16 | Four 4-bit arm fields |
| cfg_export_new | input | 1 | 1 exports updated state, 0 exports prior state |
| in_valid | input | 1 | Packet present this cycle |
| in_a | input | W | First packet field |
| in_b | input | W | Second packet field |
| out_valid | output | 1 | Result present |
| out_val | output | W | Exported state0 value |
| out_pair | output | W | Exported state1 value |
| out_flag | output | 1 | Predicate P for the packet |

## Verification

The state words are written at the same clock edge that accepts a packet, and all four outputs are registered at that edge. The effect of a packet driven before edge N is therefore visible on the outputs from edge N until the next accepted packet.

The bench drives packets and configuration together on the falling edge. On the following falling edge it compares every output against a behavioural model, which it advances at the moment it drives.

Directed checks read the outputs one falling edge after a packet was driven. An idle cycle follows the packet, so the result is stable when it is read.

// File: rtl/salu_pkg.sv
// Shared types of the stateful packet ALU.
// Assumes four arms of four configuration bits each.
package salu_pkg;

    localparam int ARMS  = 4;
    localparam int ARM_W = 4;

    typedef enum logic [2:0] {
        MD_LOAD      = 3'd0,
        MD_ACC       = 3'd1,
        MD_GUARD     = 3'd2,
        MD_SPLIT     = 3'd3,
        MD_SPLIT_SUB = 3'd4,
        MD_NEST      = 3'd5,
        MD_PAIR      = 3'd6,
        MD_HOLD      = 3'd7
    } salu_mode_e;

    typedef enum logic [1:0] {
        CMP_GT   = 2'd0,
        CMP_LT   = 2'd1,
        CMP_EQ   = 2'd2,
        CMP_TRUE = 2'd3
    } salu_cmp_e;

    typedef enum logic [1:0] {
        OPD_A    = 2'd0,
        OPD_B    = 2'd1,
        OPD_K    = 2'd2,
        OPD_ZERO = 2'd3
    } salu_opd_e;

    // bit 3 subtract, bits 2:1 operand source, bit 0 state base
    typedef struct packed {
        logic      neg;
        salu_opd_e opd;
        logic      use_state;
    } salu_arm_t;

endpackage

// File: rtl/salu_cmp.sv
// Unsigned comparator used by both predicates.
// Assumes both sides have the same width; code 3 is an unconditional true.
module salu_cmp
    import salu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   op,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic         hit
);

    salu_cmp_e op_e;
    assign op_e = salu_cmp_e'(op);

    // Select the comparison named by the code.
    always_comb begin
        case (op_e)
            CMP_GT:  hit = (lhs > rhs);
            CMP_LT:  hit = (lhs < rhs);
            CMP_EQ:  hit = (lhs == rhs);
            default: hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/salu_arm.sv
// One arithmetic arm: base (state or zero) plus or minus a chosen operand.
// Assumes the parent decides whether subtraction is permitted and whether
// the base must be forced to zero; arithmetic wraps modulo 2^W.
module salu_arm
    import salu_pkg::*;
#(
    parameter int W = 32
) (
    input  salu_arm_t    arm_cfg,
    input  logic         neg_ok,
    input  logic         zero_base,
    input  logic [W-1:0] state,
    input  logic [W-1:0] fa,
    input  logic [W-1:0] fb,
    input  logic [W-1:0] konst,
    output logic [W-1:0] res
);

    logic [W-1:0] base;
    logic [W-1:0] opnd;

    // Pick the base term.
    always_comb begin
        base = (arm_cfg.use_state && !zero_base) ? state : '0;
    end

    // Pick the operand term.
    always_comb begin
        case (arm_cfg.opd)
            OPD_A:   opnd = fa;
            OPD_B:   opnd = fb;
            OPD_K:   opnd = konst;
            default: opnd = '0;
        endcase
    end

    // Add or, when allowed and requested, subtract.
    always_comb begin
        res = (neg_ok && arm_cfg.neg) ? (base - opnd) : (base + opnd);
    end

endmodule

// File: rtl/salu_regs.sv
// Two state words written together on an accepted packet.
// Assumes the parent presents the full next value of both words.
module salu_regs #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d0,
    input  logic [W-1:0] d1,
    output logic [W-1:0] q0,
    output logic [W-1:0] q1
);

    // Hold or load both state words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q0 <= '0;
            q1 <= '0;
        end else if (we) begin
            q0 <= d0;
            q1 <= d1;
        end
    end

endmodule

// File: rtl/stateful_alu.sv
// Stateful packet ALU: single-cycle read-modify-write of one or two state
// words per packet, under a configured mode, two predicates and four arms.
// Assumes configuration is stable while packets flow; the state read for a
// packet is the register output, so back-to-back packets need no bypass.
module stateful_alu
    import salu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cfg_mode,
    input  logic [1:0]           cfg_p_op,
    input  logic                 cfg_p_lhs,
    input  logic                 cfg_p_rhs,
    input  logic [1:0]           cfg_q_op,
    input  logic [W-1:0]         cfg_k0,
    input  logic [W-1:0]         cfg_k1,
    input  logic [ARMS*ARM_W-1:0] cfg_arms,
    input  logic                 cfg_export_new,
    input  logic                 in_valid,
    input  logic [W-1:0]         in_a,
    input  logic [W-1:0]         in_b,
    output logic                 out_valid,
    output logic [W-1:0]         out_val,
    output logic [W-1:0]         out_pair,
    output logic                 out_flag
);

    salu_mode_e   mode;
    logic [W-1:0] s0, s1, n0, n1;
    logic [W-1:0] lhs, rhs;
    logic         p_hit, q_hit;
    logic         neg_ok, zero_base;
    logic [W-1:0] arm_res [ARMS];

    assign mode      = salu_mode_e'(cfg_mode);
    assign lhs       = cfg_p_lhs ? in_a : s0;
    assign rhs       = cfg_p_rhs ? cfg_k0 : in_b;
    assign neg_ok    = (mode == MD_SPLIT_SUB) || (mode == MD_NEST) || (mode == MD_PAIR);
    assign zero_base = (mode == MD_LOAD);

    salu_cmp #(.W(W)) u_cmp_p (.op(cfg_p_op), .lhs(lhs),  .rhs(rhs),  .hit(p_hit));
    salu_cmp #(.W(W)) u_cmp_q (.op(cfg_q_op), .lhs(in_a), .rhs(in_b), .hit(q_hit));

    generate
        for (genvar g = 0; g < ARMS; g++) begin : g_arm
            logic [W-1:0] arm_state;
            // Odd arms work on the second word only in pair mode.
            assign arm_state = ((mode == MD_PAIR) && (g % 2 == 1)) ? s1 : s0;
            salu_arm #(.W(W)) u_arm (
                .arm_cfg   (salu_arm_t'(cfg_arms[ARM_W*g +: ARM_W])),
                .neg_ok    (neg_ok),
                .zero_base (zero_base),
                .state     (arm_state),
                .fa        (in_a),
                .fb        (in_b),
                .konst     (cfg_k1),
                .res       (arm_res[g])
            );
        end
    endgenerate

    // Choose the next state words from the parallel arm results.
    always_comb begin
        n0 = s0;
        n1 = s1;
        case (mode)
            MD_LOAD, MD_ACC:        n0 = arm_res[0];
            MD_GUARD:               n0 = p_hit ? arm_res[0] : s0;
            MD_SPLIT, MD_SPLIT_SUB: n0 = p_hit ? arm_res[0] : arm_res[1];
            MD_NEST:                n0 = p_hit ? (q_hit ? arm_res[0] : arm_res[1])
                                               : (q_hit ? arm_res[2] : arm_res[3]);
            MD_PAIR: begin
                n0 = p_hit ? arm_res[0] : arm_res[2];
                n1 = p_hit ? arm_res[1] : arm_res[3];
            end
            default: ;
        endcase
    end

    salu_regs #(.W(W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (in_valid),
        .d0    (n0),
        .d1    (n1),
        .q0    (s0),
        .q1    (s1)
    );

    // Register the exported result of each accepted packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_val   <= '0;
            out_pair  <= '0;
            out_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_val  <= cfg_export_new ? n0 : s0;
                out_pair <= cfg_export_new ? n1 : s1;
                out_flag <= p_hit;
            end
        end
    end

    // R11: a result follows every accepted packet by one cycle
    p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R11: no result without a packet
    p_valid_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R11: exporting the prior value returns the state seen by the packet
    p_export_old_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_export_new) |=> (out_val == $past(s0)));
    // R12: idle cycles leave both words alone
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(s0) && $stable(s1)));
    // R12: hold mode leaves both words alone
    p_hold_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MD_HOLD) |=> ($stable(s0) && $stable(s1)));
    // R8: the second word moves only in pair mode
    p_single_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode != MD_PAIR) |=> $stable(s1));
    // R4: a failed guard keeps state0
    p_guard_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MD_GUARD && !p_hit) |=> $stable(s0));

endmodule

// File: tb/stateful_alu_tb.sv
module stateful_alu_tb;

    localparam int W = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n;
    logic [2:0]   cfg_mode;
    logic [1:0]   cfg_p_op, cfg_q_op;
    logic         cfg_p_lhs, cfg_p_rhs, cfg_export_new;
    logic [W-1:0] cfg_k0, cfg_k1;
    logic [15:0]  cfg_arms;
    logic         in_valid;
    logic [W-1:0] in_a, in_b;
    logic         out_valid, out_flag;
    logic [W-1:0] out_val, out_pair;

    stateful_alu #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_p_op(cfg_p_op),
        .cfg_p_lhs(cfg_p_lhs), .cfg_p_rhs(cfg_p_rhs), .cfg_q_op(cfg_q_op),
        .cfg_k0(cfg_k0), .cfg_k1(cfg_k1), .cfg_arms(cfg_arms),
        .cfg_export_new(cfg_export_new), .in_valid(in_valid), .in_a(in_a),
        .in_b(in_b), .out_valid(out_valid), .out_val(out_val),
        .out_pair(out_pair), .out_flag(out_flag)
    );

    int n_checks = 0;
    int n_fail   = 0;
    string tag = "R1";

    // staged configuration, applied together with the next packet
    logic [2:0]   c_mode = 3'd7;
    logic [1:0]   c_pop = 2'd3, c_qop = 2'd3;
    logic         c_plhs = 1'b0, c_prhs = 1'b0, c_exp = 1'b1;
    logic [W-1:0] c_k0 = '0, c_k1 = '0;
    logic [15:0]  c_arms = '0;

    // reference model state and expected outputs
    logic [W-1:0] m0 = '0, m1 = '0;
    logic         e_valid = 1'b0, e_flag = 1'b0;
    logic [W-1:0] e_val = '0, e_pair = '0;

    function automatic logic cmpf(logic [1:0] op, logic [W-1:0] l, logic [W-1:0] r);
        case (op)
            2'd0:    return l > r;
            2'd1:    return l < r;
            2'd2:    return l == r;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [W-1:0] opnd(logic [1:0] s, logic [W-1:0] a, logic [W-1:0] b);
        case (s)
            2'd0:    return a;
            2'd1:    return b;
            2'd2:    return c_k1;
            default: return '0;
        endcase
    endfunction

    function automatic logic [W-1:0] armf(int k, logic [W-1:0] st, logic [W-1:0] a,
                                          logic [W-1:0] b, logic sub_ok);
        logic [3:0]   f;
        logic [W-1:0] base;
        f = c_arms[4*k +: 4];
        base = f[0] ? st : '0;
        if (sub_ok && f[3]) return base - opnd(f[2:1], a, b);
        return base + opnd(f[2:1], a, b);
    endfunction

    task automatic check(string t, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    // One cycle: compare last expectation, then drive and advance the model.
    task automatic step(logic v, logic [W-1:0] a, logic [W-1:0] b);
        logic         p, q;
        logic [W-1:0] x0, x1;
        @(negedge clk);
        check({tag, " out_valid"}, {31'd0, out_valid}, {31'd0, e_valid});
        if (e_valid) begin
            check({tag, " out_val"},  out_val,  e_val);
            check({tag, " out_pair"}, out_pair, e_pair);
            check({tag, " out_flag"}, {31'd0, out_flag}, {31'd0, e_flag});
        end
        cfg_mode = c_mode; cfg_p_op = c_pop; cfg_q_op = c_qop;
        cfg_p_lhs = c_plhs; cfg_p_rhs = c_prhs; cfg_export_new = c_exp;
        cfg_k0 = c_k0; cfg_k1 = c_k1; cfg_arms = c_arms;
        in_valid = v; in_a = a; in_b = b;
        e_valid = v;
        if (v) begin
            p = cmpf(c_pop, c_plhs ? a : m0, c_prhs ? c_k0 : b);
            q = cmpf(c_qop, a, b);
            x0 = m0; x1 = m1;
            case (c_mode)
                3'd0: x0 = opnd(c_arms[2:1], a, b);
                3'd1: x0 = armf(0, m0, a, b, 1'b0);
                3'd2: if (p) x0 = armf(0, m0, a, b, 1'b0);
                3'd3: x0 = p ? armf(0, m0, a, b, 1'b0) : armf(1, m0, a, b, 1'b0);
                3'd4: x0 = p ? armf(0, m0, a, b, 1'b1) : armf(1, m0, a, b, 1'b1);
                3'd5: begin
                    if (p && q)  x0 = armf(0, m0, a, b, 1'b1);
                    else if (p)  x0 = armf(1, m0, a, b, 1'b1);
                    else if (q)  x0 = armf(2, m0, a, b, 1'b1);
                    else         x0 = armf(3, m0, a, b, 1'b1);
                end
                3'd6: begin
                    x0 = p ? armf(0, m0, a, b, 1'b1) : armf(2, m0, a, b, 1'b1);
                    x1 = p ? armf(1, m1, a, b, 1'b1) : armf(3, m1, a, b, 1'b1);
                end
                default: ;
            endcase
            e_val  = c_exp ? x0 : m0;
            e_pair = c_exp ? x1 : m1;
            e_flag = p;
            m0 = x0; m1 = x1;
        end
    endtask

    // Send one packet, then an idle cycle so the result can be read directly.
    task automatic one(logic [W-1:0] a, logic [W-1:0] b);
        step(1'b1, a, b);
        step(1'b0, 32'hDEAD_BEEF, 32'h1234_5678);
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0;
        cfg_mode = 3'd7; cfg_p_op = 2'd3; cfg_q_op = 2'd3; cfg_p_lhs = 1'b0;
        cfg_p_rhs = 1'b0; cfg_export_new = 1'b1; cfg_k0 = '0; cfg_k1 = '0; cfg_arms = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports, then old-state export in hold mode
        @(negedge clk);
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 out_val", out_val, '0);
        check("R1 out_pair", out_pair, '0);
        check("R1 out_flag", {31'd0, out_flag}, 32'd0);
        tag = "R1"; c_mode = 3'd7; c_exp = 1'b0;
        one(32'h55, 32'h66);
        check("R1 state0 zero", out_val, '0);
        check("R1 state1 zero", out_pair, '0);

        // R2: load from field and from constant, base/subtract ignored
        tag = "R2"; c_mode = 3'd0; c_exp = 1'b1; c_arms = 16'h0009;
        one(32'h1234, 32'h9);
        check("R2 load field", out_val, 32'h1234);
        c_arms = 16'h000D; c_k1 = 32'hCAFE;
        one(32'h1, 32'h2);
        check("R2 load const", out_val, 32'hCAFE);

        // R3: accumulate with wrap, subtract bit ignored
        tag = "R3"; c_arms = 16'h0004; c_k1 = 32'hFFFF_FFFF;
        one(0, 0);
        c_mode = 3'd1; c_arms = 16'h0005; c_k1 = 32'd2;
        one(0, 0);
        check("R3 wrap", out_val, 32'd1);
        c_arms = 16'h000D;
        one(0, 0);
        check("R3 sub ignored", out_val, 32'd3);

        // R4: guarded add, state0 > in_b
        tag = "R4"; c_mode = 3'd2; c_arms = 16'h0001; c_pop = 2'd0; c_plhs = 1'b0; c_prhs = 1'b0;
        one(32'd5, 32'd10);
        check("R4 guard false hold", out_val, 32'd3);
        one(32'd5, 32'd1);
        check("R4 guard true add", out_val, 32'd8);

        // R5: two-way, in_a < in_b, subtract ignored
        tag = "R5"; c_mode = 3'd3; c_arms = 16'h00B1; c_pop = 2'd1; c_plhs = 1'b1;
        one(32'd2, 32'd7);
        check("R5 true arm", out_val, 32'd10);
        one(32'd9, 32'd4);
        check("R5 false arm sub ignored", out_val, 32'd14);

        // R6: two-way with subtraction honoured
        tag = "R6"; c_mode = 3'd4;
        one(32'd9, 32'd4);
        check("R6 subtract arm", out_val, 32'd10);
        one(32'd1, 32'd5);
        check("R6 add arm", out_val, 32'd11);

        // R7: nested, P = in_a > k0(100), Q = in_a == in_b
        tag = "R7"; c_mode = 3'd5; c_arms = 16'h9420; c_pop = 2'd0; c_plhs = 1'b1;
        c_prhs = 1'b1; c_k0 = 32'd100; c_qop = 2'd2; c_k1 = 32'h77;
        one(32'd200, 32'd200);
        check("R7 P Q", out_val, 32'd200);
        one(32'd200, 32'd5);
        check("R7 P notQ", out_val, 32'd5);
        one(32'd7, 32'd7);
        check("R7 notP Q", out_val, 32'h77);
        one(32'd7, 32'd8);
        check("R7 notP notQ", out_val, 32'h70);

        // R8: pair, P = in_a < in_b
        tag = "R8"; c_mode = 3'd6; c_arms = 16'h5931; c_pop = 2'd1; c_prhs = 1'b0; c_k1 = 32'd4;
        one(32'd1, 32'd2);
        check("R8 true word0", out_val, 32'h71);
        check("R8 true word1", out_pair, 32'd2);
        one(32'd3, 32'd1);
        check("R8 false word0", out_val, 32'h6E);
        check("R8 false word1", out_pair, 32'd6);
        c_mode = 3'd1; c_arms = 16'h0001;
        one(32'd1, 32'd0);
        check("R8 word1 untouched", out_pair, 32'd6);

        // R9: predicate codes, unsigned, in_a vs in_b
        tag = "R9"; c_mode = 3'd7; c_plhs = 1'b1; c_prhs = 1'b0;
        c_pop = 2'd0; one(32'd5, 32'd3);
        check("R9 gt true", {31'd0, out_flag}, 32'd1);
        one(32'd3, 32'd5);
        check("R9 gt false", {31'd0, out_flag}, 32'd0);
        c_pop = 2'd1; one(32'hFFFF_FFFF, 32'd1);
        check("R9 lt unsigned", {31'd0, out_flag}, 32'd0);
        c_pop = 2'd2; one(32'd9, 32'd9);
        check("R9 eq", {31'd0, out_flag}, 32'd1);
        c_pop = 2'd3; one(32'd1, 32'd9);
        check("R9 always", {31'd0, out_flag}, 32'd1);

        // R10: back-to-back accumulation
        tag = "R10"; c_mode = 3'd0; c_arms = 16'h0006; one(0, 0);
        c_mode = 3'd1; c_arms = 16'h0001;
        for (int i = 1; i <= 8; i++) step(1'b1, i, 0);
        step(1'b0, 0, 0);
        check("R10 running sum", out_val, 32'd36);

        // R11/R12: idle junk, then hold mode exporting old value
        tag = "R12";
        for (int i = 0; i < 4; i++) step(1'b0, 32'hFFFF_0000 + i, 32'h1);
        c_mode = 3'd7; c_exp = 1'b0;
        one(32'h9999, 32'h8888);
        check("R12 idle keeps state", out_val, 32'd36);
        tag = "R11"; c_mode = 3'd1; c_arms = 16'h0001;
        one(32'd4, 32'd0);
        check("R11 export old", out_val, 32'd36);
        c_exp = 1'b1; c_mode = 3'd7;
        one(0, 0);
        check("R11 export new", out_val, 32'd40);

        // R13: sampling counter
        tag = "R13"; c_mode = 3'd0; c_arms = 16'h0006; one(0, 0);
        c_mode = 3'd3; c_pop = 2'd2; c_plhs = 1'b0; c_prhs = 1'b1; c_k0 = 32'd9;
        c_k1 = 32'd1; c_arms = 16'h0056;
        for (int i = 1; i <= 20; i++) begin
            one(0, 0);
            check("R13 count", out_val, i % 10);
            check("R13 mark", {31'd0, out_flag}, (i % 10 == 0) ? 32'd1 : 32'd0);
        end

        // random mix compared against the model each cycle
        tag = "R10 mix";
        for (int i = 0; i < 400; i++) begin
            c_mode = 3'($urandom); c_pop = 2'($urandom); c_qop = 2'($urandom);
            c_plhs = 1'($urandom); c_prhs = 1'($urandom); c_exp = 1'($urandom);
            c_k0 = $urandom % 8; c_k1 = $urandom; c_arms = 16'($urandom);
            if (i % 2 == 0) step(1'($urandom), $urandom % 8, $urandom % 8);
            else            step(1'($urandom), $urandom, $urandom);
        end
        step(1'b0, 0, 0);
        step(1'b0, 0, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule